// File: doc/BRIEF.md
# Key Event Queue with Consuming and Non-Consuming Reads

This block buffers key events for a keypad controller. Each event arrives as a 7-bit key code plus one bit that tells press from release, and it is stored as one byte in a 16-slot circular buffer. The buffer is tracked by a head index and an occupancy count, and both wrap on a power-of-two boundary.

Two read modes are offered. A consuming read first moves the head forward by one slot and then returns the byte found at the new head. It does this only when at least two entries are held, and otherwise it answers zero. As a result, the oldest entry is dropped without ever being returned. A non-consuming read returns the byte at a chosen offset from the head, or zero when the offset lies past the held entries, and leaves the buffer unchanged.

Accepted events raise a one-cycle keypad pulse toward the interrupt controller. An event that finds the buffer full raises a one-cycle overflow pulse and sets a sticky lock. The lock stays set until the error controller releases it. While the lock is set, every event is discarded. A configuration clear empties the buffer and drops the lock.

Top module: `kevt_fifo`

## Requirements
- R1: After synchronous reset the queue is empty (a peek at offset 0 returns 0x00), and rd_valid, rd_data, kp_set and ovf_set are all 0.
- R2: A stored entry is the key code in bits 6:0 with evt_pressed in bit 7.
- R3: An event accepted at a clock edge is stored at slot (head + count) mod 16 and raises the count by one. kp_set is high for exactly the following cycle.
- R4: An event arriving while 16 entries are held is discarded. ovf_set is high for the following cycle, kp_set stays low, and the lock is set.
- R5: While the lock is set, every event is discarded with neither kp_set nor ovf_set, and stored entries stay unchanged.
- R6: A lock_clr pulse releases the lock from the next cycle on. An event in the same cycle as lock_clr is still discarded.
- R7: A consuming read while the count is 0 or 1 returns 0x00 and leaves head and count unchanged.
- R8: A consuming read while the count is 2 or more moves the head forward by one, lowers the count by one and returns the entry at the new head.
- R9: A peek at offset k with k >= count returns 0x00 and has no effect.
- R10: A peek at offset k < count returns the entry at (head + k) mod 16 and has no effect.
- R11: cfg_clr empties the queue and releases the lock. It takes precedence over any event or read in the same cycle, and such reads get no response.
- R12: An event and a consuming read in the same cycle both take effect. The read sees the contents from before the edge, and the count ends unchanged.
- R13: Every consuming or peek request not masked by cfg_clr gets exactly one response: rd_valid is high in the next cycle. When both request kinds arrive together, the consuming read is served and the peek is dropped.
- R14: The head and the write slot wrap from 15 to 0, so entries stay in order across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Key event present this cycle |
| evt_code | input | 7 | Key code of the event |
| evt_pressed | input | 1 | 1 = press, 0 = release |
| cfg_clr | input | 1 | Configuration clear: empty queue, release lock |
| lock_clr | input | 1 | Release the overflow lock |
| cons_req | input | 1 | Consuming read request |
| peek_req | input | 1 | Peek read request |
| peek_off | input | 8 | Peek offset from the head |
| rd_valid | output | 1 | Read response valid (one cycle after request) |
| rd_data | output | 8 | Read response byte, 0x00 when no response |
| kp_set | output | 1 | Pulse: an event was accepted |
| ovf_set | output | 1 | Pulse: an event hit a full queue |

## Verification
A corrupted head index or count shows up on the very next read response. Peeks expose every held entry and the exact boundary at the count, and a consuming read exposes the head position. The bench therefore issues peeks at and just past the count after each kind of update. A lock that is set wrongly or stuck shows within one cycle of the next event, as a missing kp_set or a missing or extra ovf_set. Same-cycle combinations of event, consume, peek and clear are driven both in directed cases and in a long randomized stretch, and every cycle's outputs are compared with a queue-based model.

// File: rtl/kevt_pkg.sv
package kevt_pkg;

    // Kind of read response prepared for the next cycle.
    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_ZERO = 2'd1,
        RSP_HIT  = 2'd2
    } rsp_kind_e;

    // Per-cycle decision of the queue controller.
    typedef struct packed {
        logic accept;    // event is stored
        logic overflow;  // event hit a full queue
        logic cons_hit;  // consuming read advances the head
        logic read_any;  // a read response is owed
        logic read_hit;  // the response carries stored data
    } kf_dec_t;

    function automatic rsp_kind_e pick_rsp(input kf_dec_t d);
        if (!d.read_any)
            return RSP_NONE;
        return d.read_hit ? RSP_HIT : RSP_ZERO;
    endfunction

endpackage

// File: rtl/kf_store.sv
module kf_store #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 8,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [PTR_W-1:0]   rd_addr,
    output logic [ENTRY_W-1:0] rd_word
);

    logic [ENTRY_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [ENTRY_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == PTR_W'(g)))
                cell_q <= wr_data;
        end
        assign slot_q[g] = cell_q;
    end

    // Read of the pre-edge contents.
    assign rd_word = slot_q[rd_addr];

endmodule

// File: rtl/kf_ctrl.sv
module kf_ctrl
    import kevt_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int OFFS_W  = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int LEN_W  = PTR_W + 1,
    localparam int CMP_W  = (OFFS_W > LEN_W) ? OFFS_W : LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic              cfg_clr,
    input  logic              lock_clr,
    input  logic              cons_req,
    input  logic              peek_req,
    input  logic [OFFS_W-1:0] peek_off,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [PTR_W-1:0]  rd_addr,
    output rsp_kind_e         rsp_kind,
    output logic              kp_set,
    output logic              ovf_set,
    output logic [LEN_W-1:0]  fill,
    output logic              lock
);

    logic [PTR_W-1:0] head_q;
    logic [LEN_W-1:0] fill_q;
    logic             lock_q;
    logic             kp_q;
    logic             ovf_q;
    kf_dec_t          dec;
    logic             full;
    logic             live_evt;
    logic             cons_go;
    logic             peek_go;
    logic             peek_in;

    assign full     = (fill_q == LEN_W'(DEPTH));
    assign live_evt = evt_valid && !cfg_clr && !lock_q;
    assign cons_go  = cons_req && !cfg_clr;
    assign peek_go  = peek_req && !cons_req && !cfg_clr;
    assign peek_in  = (CMP_W'(peek_off) < CMP_W'(fill_q));

    always_comb begin
        dec          = '0;
        dec.accept   = live_evt && !full;
        dec.overflow = live_evt && full;
        dec.cons_hit = cons_go && (fill_q > LEN_W'(1));
        dec.read_any = cons_go || peek_go;
        dec.read_hit = dec.cons_hit || (peek_go && peek_in);
    end

    assign wr_en    = dec.accept;
    assign wr_addr  = head_q + fill_q[PTR_W-1:0];
    assign rd_addr  = cons_go ? (head_q + PTR_W'(1))
                              : (head_q + peek_off[PTR_W-1:0]);
    assign rsp_kind = pick_rsp(dec);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            fill_q <= '0;
            lock_q <= 1'b0;
            kp_q   <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            kp_q  <= dec.accept;
            ovf_q <= dec.overflow;
            if (cfg_clr) begin
                head_q <= '0;
                fill_q <= '0;
                lock_q <= 1'b0;
            end else begin
                if (dec.cons_hit)
                    head_q <= head_q + PTR_W'(1);
                case ({dec.accept, dec.cons_hit})
                    2'b10:   fill_q <= fill_q + LEN_W'(1);
                    2'b01:   fill_q <= fill_q - LEN_W'(1);
                    default: fill_q <= fill_q;
                endcase
                if (dec.overflow)
                    lock_q <= 1'b1;
                else if (lock_clr)
                    lock_q <= 1'b0;
            end
        end
    end

    assign kp_set  = kp_q;
    assign ovf_set = ovf_q;
    assign fill    = fill_q;
    assign lock    = lock_q;

endmodule

// File: rtl/kf_resp.sv
module kf_resp
    import kevt_pkg::*;
#(
    parameter int ENTRY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  rsp_kind_e          rsp_kind,
    input  logic [ENTRY_W-1:0] rd_word,
    output logic               rd_valid,
    output logic [ENTRY_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (rsp_kind != RSP_NONE);
            rd_data  <= (rsp_kind == RSP_HIT) ? rd_word : '0;
        end
    end

endmodule

// File: rtl/kevt_fifo.sv
module kevt_fifo
    import kevt_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int CODE_W  = 7,
    parameter int OFFS_W  = 8,
    localparam int ENTRY_W = CODE_W + 1,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int LEN_W   = PTR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    input  logic [CODE_W-1:0]  evt_code,
    input  logic               evt_pressed,
    input  logic               cfg_clr,
    input  logic               lock_clr,
    input  logic               cons_req,
    input  logic               peek_req,
    input  logic [OFFS_W-1:0]  peek_off,
    output logic               rd_valid,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               kp_set,
    output logic               ovf_set
);

    logic                wr_en;
    logic [PTR_W-1:0]    wr_addr;
    logic [PTR_W-1:0]    rd_addr;
    logic [ENTRY_W-1:0]  wr_data;
    logic [ENTRY_W-1:0]  rd_word;
    rsp_kind_e           rsp_kind;
    logic [LEN_W-1:0]    fill;
    logic                lock;

    // Press/release state lands in the top bit of the entry.
    assign wr_data = {evt_pressed, evt_code};

    kf_ctrl #(
        .DEPTH  (DEPTH),
        .OFFS_W (OFFS_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .cfg_clr   (cfg_clr),
        .lock_clr  (lock_clr),
        .cons_req  (cons_req),
        .peek_req  (peek_req),
        .peek_off  (peek_off),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .rsp_kind  (rsp_kind),
        .kp_set    (kp_set),
        .ovf_set   (ovf_set),
        .fill      (fill),
        .lock      (lock)
    );

    kf_store #(
        .DEPTH   (DEPTH),
        .ENTRY_W (ENTRY_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    kf_resp #(
        .ENTRY_W (ENTRY_W)
    ) u_resp (
        .clk      (clk),
        .rst      (rst),
        .rsp_kind (rsp_kind),
        .rd_word  (rd_word),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/kevt_fifo_chk.sv
module kevt_fifo_chk #(
    parameter int DEPTH  = 16,
    localparam int LEN_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             evt_valid,
    input logic             cfg_clr,
    input logic             cons_req,
    input logic             peek_req,
    input logic             rd_valid,
    input logic             kp_set,
    input logic             ovf_set,
    input logic [LEN_W-1:0] fill,
    input logic             lock
);

    // R3: occupancy never exceeds the depth
    p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= LEN_W'(DEPTH));

    // R3: an event meeting free space and no lock is reported next cycle
    p_accept_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !cfg_clr && !lock && fill < LEN_W'(DEPTH)) |=> kp_set);

    // R4: accept and overflow pulses never coincide
    p_pulse_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(kp_set && ovf_set));

    // R4: an overflow pulse comes with the lock held
    p_ovf_locks_r4: assert property (@(posedge clk) disable iff (rst)
        ovf_set |-> lock);

    // R5: a held lock suppresses both pulses on the next cycle
    p_lock_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        lock |=> (!kp_set && !ovf_set));

    // R11: configuration clear empties the queue and frees the lock
    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_clr |=> (fill == '0 && !lock));

    // R12: occupancy moves by at most one per cycle outside a clear
    p_fill_step_r12: assert property (@(posedge clk) disable iff (rst)
        !cfg_clr |=> ((int'(fill) <= int'($past(fill)) + 1) &&
                      (int'(fill) + 1 >= int'($past(fill)))));

    // R13: each unmasked request gets a response next cycle
    p_resp_r13: assert property (@(posedge clk) disable iff (rst)
        ((cons_req || peek_req) && !cfg_clr) |=> rd_valid);

    // R13: no request, no response
    p_no_resp_r13: assert property (@(posedge clk) disable iff (rst)
        !(cons_req || peek_req) |=> !rd_valid);

endmodule

bind kevt_fifo kevt_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .cfg_clr   (cfg_clr),
    .cons_req  (cons_req),
    .peek_req  (peek_req),
    .rd_valid  (rd_valid),
    .kp_set    (kp_set),
    .ovf_set   (ovf_set),
    .fill      (fill),
    .lock      (lock)
);

// File: tb/tb_kevt_fifo.sv
module tb_kevt_fifo;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_valid = 1'b0;
    logic [6:0] evt_code = '0;
    logic       evt_pressed = 1'b0;
    logic       cfg_clr = 1'b0;
    logic       lock_clr = 1'b0;
    logic       cons_req = 1'b0;
    logic       peek_req = 1'b0;
    logic [7:0] peek_off = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       kp_set;
    logic       ovf_set;

    int total = 0;
    int bad   = 0;

    // Behavioural model: queue front is the head entry.
    byte unsigned mq[$];
    bit           m_lock = 1'b0;

    always #2 clk = ~clk;

    kevt_fifo dut (
        .clk         (clk),
        .rst         (rst),
        .evt_valid   (evt_valid),
        .evt_code    (evt_code),
        .evt_pressed (evt_pressed),
        .cfg_clr     (cfg_clr),
        .lock_clr    (lock_clr),
        .cons_req    (cons_req),
        .peek_req    (peek_req),
        .peek_off    (peek_off),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .kp_set      (kp_set),
        .ovf_set     (ovf_set)
    );

    task automatic check(input string tag, input bit av, input byte unsigned ad,
                         input bit ak, input bit ao, input bit ev, input byte unsigned ed,
                         input bit ek, input bit eo);
        total++;
        if (av !== ev || ad !== ed || ak !== ek || ao !== eo) begin
            bad++;
            $display("FAIL %s: got v=%0b d=%02h kp=%0b ovf=%0b, expected v=%0b d=%02h kp=%0b ovf=%0b",
                     tag, av, ad, ak, ao, ev, ed, ek, eo);
        end
    endtask

    task automatic step(input bit ev, input byte unsigned code, input bit pr,
                        input bit cons, input bit pk, input int off,
                        input bit clr, input bit lclr, input string tag);
        bit           e_v = 1'b0;
        byte unsigned e_d = 8'h00;
        bit           e_k = 1'b0;
        bit           e_o = 1'b0;
        int           sz  = mq.size();
        // expected outputs from the state before the edge
        if (clr) begin
            mq.delete();
            m_lock = 1'b0;
        end else begin
            if (cons) begin
                e_v = 1'b1;
                e_d = (sz > 1) ? mq[1] : 8'h00;
            end else if (pk) begin
                e_v = 1'b1;
                e_d = (off < sz) ? mq[off] : 8'h00;
            end
            if (ev && !m_lock) begin
                if (sz == 16) begin
                    e_o = 1'b1;
                end else begin
                    e_k = 1'b1;
                    mq.push_back({pr, code[6:0]});
                end
            end
            if (cons && sz > 1)
                void'(mq.pop_front());
            if (e_o)
                m_lock = 1'b1;
            else if (lclr)
                m_lock = 1'b0;
        end
        @(negedge clk);
        evt_valid   = ev;
        evt_code    = code[6:0];
        evt_pressed = pr;
        cons_req    = cons;
        peek_req    = pk;
        peek_off    = off[7:0];
        cfg_clr     = clr;
        lock_clr    = lclr;
        @(posedge clk);
        #1;
        check(tag, rd_valid, rd_data, kp_set, ovf_set, e_v, e_d, e_k, e_o);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic push(input byte unsigned code, input bit pr, input string tag);
        step(1, code, pr, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic peek(input int off, input string tag);
        step(0, 0, 0, 0, 1, off, 0, 0, tag);
    endtask

    task automatic consume(input string tag);
        step(0, 0, 0, 1, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1: reset state of the outputs
        check("R1 outputs", rd_valid, rd_data, kp_set, ovf_set, 0, 8'h00, 0, 0);
        peek(0, "R1 empty peek");
        consume("R1 empty consume");

        // R2, R3: stored byte layout and accept pulse
        push(8'h3c, 1, "R2 press bit");
        peek(0, "R2 press byte");
        push(8'h55, 0, "R3 second event");
        push(8'h01, 1, "R3 third event");
        // R10: peeks inside the count, R9: at and past it
        peek(1, "R10 offset 1");
        peek(2, "R10 offset 2");
        peek(3, "R9 offset at count");
        peek(200, "R9 offset far past count");
        peek(2, "R9 no effect after miss");

        // R8: consume skips the old head
        consume("R8 advance");
        peek(0, "R8 new head");
        peek(1, "R8 remaining");
        consume("R8 advance to last");
        // R7: one entry left, consume refuses
        consume("R7 single entry");
        peek(0, "R7 head kept");
        peek(1, "R7 count kept");

        // R12: event plus consume in one cycle
        push(8'h11, 0, "R12 setup");
        step(1, 8'h22, 1, 1, 0, 0, 0, 0, "R12 event with consume");
        peek(0, "R12 head after");
        peek(1, "R12 new tail");
        peek(2, "R12 count unchanged");

        // R13: consume and peek together, consume served
        push(8'h33, 0, "R13 setup");
        step(0, 0, 0, 1, 1, 2, 0, 0, "R13 consume wins");
        peek(0, "R13 head after");

        // R4: fill to 16 then overflow
        for (int i = 0; i < 20; i++) begin
            if (mq.size() < 16) push(8'(8'h40 + i), i[0], "R4 fill");
        end
        peek(15, "R4 last slot");
        push(8'h7f, 1, "R4 overflow drop");
        // R5: locked events ignored, contents stay
        consume("R5 make room");
        push(8'h70, 0, "R5 blocked event");
        peek(14, "R5 last entry");
        peek(15, "R5 nothing appended");
        // R6: release same cycle as event: event still dropped
        step(1, 8'h71, 0, 0, 0, 0, 0, 1, "R6 event with release");
        push(8'h72, 1, "R6 accepted after release");
        peek(15, "R6 appended");

        // R11: clear with event and read in the same cycle
        push(8'h73, 0, "R11 overflow again");
        step(1, 8'h74, 0, 1, 0, 0, 1, 0, "R11 clear dominates");
        peek(0, "R11 empty");
        push(8'h05, 0, "R11 lock released");
        peek(0, "R11 fresh head");

        // R14: run the head around the ring several times
        for (int i = 0; i < 40; i++) begin
            push(8'(i * 3), i[1], "R14 wrap push");
            consume("R14 wrap consume");
            peek(0, "R14 wrap head");
        end
        step(0, 0, 0, 0, 0, 0, 1, 0, "R11 clear before mix");

        // R12, R13: randomized mix of simultaneous requests
        for (int i = 0; i < 3000; i++) begin
            step(($urandom_range(0, 99) < 60), 8'($urandom_range(0, 127)),
                 $urandom_range(0, 1) == 1, ($urandom_range(0, 99) < 25),
                 ($urandom_range(0, 99) < 40), $urandom_range(0, 20),
                 ($urandom_range(0, 299) == 0), ($urandom_range(0, 19) == 0),
                 "R12 mixed traffic");
        end
        idle("R13 idle tail");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule